// File: doc/BRIEF.md
# GPIO Controller with Alternate-Function Mux

A fourteen-pin general-purpose I/O controller sits on a simple 32-bit register bus that has an address, a write strobe, write data and combinational read data. Software uses it in two ways. It can drive each pin as a plain I/O with its own direction and output value, or it can give the pin to an on-chip peripheral signal. A pin in peripheral mode takes a direction fixed at design time. Ten pins drive out and four pins feed in.

Every pin is compared with a programmed level bit on every clock. When they are equal, a sticky status bit is set. Software clears a status bit by writing a one to it. A per-pin enable sends each pending status bit to one of two outputs: a non-maskable interrupt line or the ordinary interrupt line.

Top module: `gpio_altmux`

## Requirements
- R1: While rst_ni is low, every register is 0. No pin is output-enabled, pad_out_o is 0, alt_in_o is 0, and irq_o and nmi_o are 0.
- R2: The word registers are decoded from bus_addr_i[4:2] as follows: 0 = function select, 1 = direction, 2 = data, 3 = match level, 4 = status, 5 = NMI enable. Words 6 and 7 read 0, and read-data bits 31..14 are always 0. A write takes effect at the clock edge.
- R3: A pin with function bit 0 is a plain I/O. With direction bit 1 it sets pad_oe_o=1 and pad_out_o equal to its data bit. With direction bit 0 it sets pad_oe_o=0 and pad_out_o=0.
- R4: A pin with function bit 1 takes a fixed direction. Pins 0,2,4,5,6,7,8,10,12,13 drive pad_oe_o=1 with pad_out_o=alt_out_i. Pins 1,3,9,11 drive pad_oe_o=0 and pass pad_in_i to alt_in_o. alt_in_o is 0 for every other pin.
- R5: A read of the data word returns the pin state. For an output-enabled pin this is the driven value, and for any other pin it is pad_in_i.
- R6: If a pin state equals its level bit in a cycle, that pin's status bit is 1 after the next clock edge.
- R7: A status bit that is set stays set until a write of 1 to that bit of the status word.
- R8: A status write clears only the bits written as 1. If the match condition holds in the same cycle, the bit stays set.
- R9: irq_o is the OR of the status bits whose NMI enable bit is 0. nmi_o is the OR of the status bits whose NMI enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 5 | Byte address of the register word |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pad_in_i | input | 14 | Sampled pin levels |
| pad_out_o | output | 14 | Pin output values |
| pad_oe_o | output | 14 | Pin output enables |
| alt_out_i | input | 14 | Output signals from the peripherals |
| alt_in_o | output | 14 | Pin levels delivered to the peripherals |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The pins are driven with fixed checkerboard and nibble patterns while software mixes input and output directions. These patterns separate a data read of the driven value from a data read of the pad value, and they separate a plain-I/O pin from a peripheral pin on the same bit. The level register is switched between all-ones and a pattern that only partly matches the pins, so the bench can show both that status is set and that it is not cleared when the match goes away. A status clear is issued while the match still holds and again after the match has gone, which shows that a set wins over a clear. A long run of pseudo-random bus traffic and pin values, checked against the bench model every cycle, covers the mixed cases.

// File: rtl/gpio_altmux_pkg.sv
package gpio_altmux_pkg;
  typedef enum logic [2:0] {
    RG_FUNC  = 3'd0,
    RG_DIR   = 3'd1,
    RG_DATA  = 3'd2,
    RG_LEVEL = 3'd3,
    RG_STAT  = 3'd4,
    RG_NMIEN = 3'd5
  } reg_idx_e;

  localparam int unsigned BUS_W = 32;
endpackage

// File: rtl/gpio_altmux_regs.sv
module gpio_altmux_regs
  import gpio_altmux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 14,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BUS_W-1:0]    wdata_i,
  input  logic [NUM_PINS-1:0] pin_state_i,
  input  logic [NUM_PINS-1:0] status_i,
  output logic [NUM_PINS-1:0] func_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] nmien_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [BUS_W-1:0]    rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    idx;
  logic [NUM_PINS-1:0] wd;
  logic                unused_bits;

  assign idx         = addr_i[ADDR_W-1:2];
  assign wd          = wdata_i[NUM_PINS-1:0];
  assign unused_bits = ^{wdata_i[BUS_W-1:NUM_PINS], addr_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_o  <= '0;
      dir_o   <= '0;
      data_o  <= '0;
      level_o <= '0;
      nmien_o <= '0;
    end else if (we_i) begin
      case (idx)
        IDX_W'(RG_FUNC):  func_o  <= wd;
        IDX_W'(RG_DIR):   dir_o   <= wd;
        IDX_W'(RG_DATA):  data_o  <= wd;
        IDX_W'(RG_LEVEL): level_o <= wd;
        IDX_W'(RG_NMIEN): nmien_o <= wd;
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && idx == IDX_W'(RG_STAT)) ? wd : '0;

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_W'(RG_FUNC):  rdata_o[NUM_PINS-1:0] = func_o;
      IDX_W'(RG_DIR):   rdata_o[NUM_PINS-1:0] = dir_o;
      IDX_W'(RG_DATA):  rdata_o[NUM_PINS-1:0] = pin_state_i;
      IDX_W'(RG_LEVEL): rdata_o[NUM_PINS-1:0] = level_o;
      IDX_W'(RG_STAT):  rdata_o[NUM_PINS-1:0] = status_i;
      IDX_W'(RG_NMIEN): rdata_o[NUM_PINS-1:0] = nmien_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_altmux_pad.sv
module gpio_altmux_pad #(
  parameter int unsigned       NUM_PINS     = 14,
  parameter logic [NUM_PINS-1:0] ALT_OUT_MASK = 14'h35F5
) (
  input  logic [NUM_PINS-1:0] func_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] data_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] alt_out_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] alt_in_o,
  output logic [NUM_PINS-1:0] pin_state_o
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    if (ALT_OUT_MASK[n]) begin : g_alt_drv
      assign pad_oe_o[n]  = func_i[n] | dir_i[n];
      assign pad_out_o[n] = func_i[n] ? alt_out_i[n] : (dir_i[n] & data_i[n]);
      assign alt_in_o[n]  = 1'b0;
    end else begin : g_alt_rcv
      logic unused_alt;
      assign unused_alt   = alt_out_i[n];
      assign pad_oe_o[n]  = ~func_i[n] & dir_i[n];
      assign pad_out_o[n] = ~func_i[n] & dir_i[n] & data_i[n];
      assign alt_in_o[n]  = func_i[n] & pad_in_i[n];
    end
    assign pin_state_o[n] = pad_oe_o[n] ? pad_out_o[n] : pad_in_i[n];
  end
endmodule

// File: rtl/gpio_altmux_evt.sv
module gpio_altmux_evt #(
  parameter int unsigned NUM_PINS = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_state_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] nmien_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o,
  output logic                nmi_o
);
  logic [NUM_PINS-1:0] match;

  assign match = ~(pin_state_i ^ level_i);

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | match;
  end

  assign irq_o = |(status_o & ~nmien_i);
  assign nmi_o = |(status_o & nmien_i);
endmodule

// File: rtl/gpio_altmux.sv
module gpio_altmux
  import gpio_altmux_pkg::*;
#(
  parameter int unsigned         NUM_PINS     = 14,
  parameter int unsigned         ADDR_W       = 5,
  parameter logic [NUM_PINS-1:0] ALT_OUT_MASK = 14'h35F5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] alt_out_i,
  output logic [NUM_PINS-1:0] alt_in_o,
  output logic                irq_o,
  output logic                nmi_o
);
  logic [NUM_PINS-1:0] func_q, dir_q, data_q, level_q, nmien_q;
  logic [NUM_PINS-1:0] status_q, clr_mask, pin_state;

  gpio_altmux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .wdata_i     (bus_wdata_i),
    .pin_state_i (pin_state),
    .status_i    (status_q),
    .func_o      (func_q),
    .dir_o       (dir_q),
    .data_o      (data_q),
    .level_o     (level_q),
    .nmien_o     (nmien_q),
    .clr_o       (clr_mask),
    .rdata_o     (bus_rdata_o)
  );

  gpio_altmux_pad #(.NUM_PINS(NUM_PINS), .ALT_OUT_MASK(ALT_OUT_MASK)) u_pad (
    .func_i      (func_q),
    .dir_i       (dir_q),
    .data_i      (data_q),
    .pad_in_i,
    .alt_out_i,
    .pad_out_o,
    .pad_oe_o,
    .alt_in_o,
    .pin_state_o (pin_state)
  );

  gpio_altmux_evt #(.NUM_PINS(NUM_PINS)) u_evt (
    .clk_i, .rst_ni,
    .pin_state_i (pin_state),
    .level_i     (level_q),
    .clr_i       (clr_mask),
    .nmien_i     (nmien_q),
    .status_o    (status_q),
    .irq_o,
    .nmi_o
  );
endmodule

// File: rtl/gpio_altmux_chk.sv
module gpio_altmux_chk #(
  parameter int unsigned NUM_PINS = 14,
  parameter int unsigned ADDR_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic                bus_we_i,
  input logic [31:0]         bus_wdata_i,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] alt_in_o,
  input logic [NUM_PINS-1:0] func_q,
  input logic [NUM_PINS-1:0] level_q,
  input logic [NUM_PINS-1:0] status_q,
  input logic                irq_o,
  input logic                nmi_o
);
  logic [NUM_PINS-1:0] seen_state, seen_match, wr_clr;

  assign seen_state = (pad_oe_o & pad_out_o) | (~pad_oe_o & pad_in_i);
  assign seen_match = ~(seen_state ^ level_q);
  assign wr_clr     = (bus_we_i && bus_addr_i[ADDR_W-1:2] == 3'd4)
                      ? bus_wdata_i[NUM_PINS-1:0] : '0;

  always @(negedge clk_i)
    if (!rst_ni) a_r1_reset_quiet: assert (pad_oe_o == '0 && status_q == '0 && !irq_o && !nmi_o);

  a_r3_no_drive_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);

  a_r4_alt_in_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_in_o & ~func_q) == '0);

  a_r6_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(seen_match)) == $past(seen_match)));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q) & ~$past(wr_clr)) & ~status_q) == '0));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> (!irq_o && !nmi_o));

  a_r9_some_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || nmi_o) |-> (status_q != '0));
endmodule

bind gpio_altmux gpio_altmux_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_altmux_tb.sv
module gpio_altmux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [13:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_in;
  logic        irq, nmi;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [13:0] m_func = '0, m_dir = '0, m_data = '0, m_lvl = '0, m_stat = '0, m_nmie = '0;
  logic [13:0] alt_drives;

  always #4 clk = ~clk;

  gpio_altmux u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .alt_out_i(alt_out), .alt_in_o(alt_in), .irq_o(irq), .nmi_o(nmi)
  );

  function automatic logic [13:0] exp_oe();
    logic [13:0] r;
    for (int n = 0; n < 14; n++) r[n] = m_func[n] ? alt_drives[n] : m_dir[n];
    return r;
  endfunction

  function automatic logic [13:0] exp_out();
    logic [13:0] r, oe;
    oe = exp_oe();
    for (int n = 0; n < 14; n++)
      r[n] = !oe[n] ? 1'b0 : (m_func[n] ? alt_out[n] : m_data[n]);
    return r;
  endfunction

  function automatic logic [13:0] exp_state();
    logic [13:0] r, oe, o;
    oe = exp_oe();
    o  = exp_out();
    for (int n = 0; n < 14; n++) r[n] = oe[n] ? o[n] : pad_in[n];
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (addr[4:2])
      3'd0: return {18'd0, m_func};
      3'd1: return {18'd0, m_dir};
      3'd2: return {18'd0, exp_state()};
      3'd3: return {18'd0, m_lvl};
      3'd4: return {18'd0, m_stat};
      3'd5: return {18'd0, m_nmie};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string fld, input logic [31:0] act, input logic [31:0] expv);
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", tag, fld, act, expv, $time);
    end
  endtask

  task automatic cyc(input logic [4:0] a, input logic w, input logic [31:0] d,
                     input logic [13:0] pin, input logic [13:0] alt, input string tag);
    logic [13:0] st, clr, aexp;
    addr = a; we = w; wdata = d; pad_in = pin; alt_out = alt;
    #2;
    vectors++;
    for (int n = 0; n < 14; n++) aexp[n] = m_func[n] && !alt_drives[n] ? pin[n] : 1'b0;
    cmp({tag, " R2 R5 R6 R7 R8"}, "rdata", rdata, exp_rdata());
    cmp({tag, " R3 R4"}, "pad_oe", 32'(pad_oe), 32'(exp_oe()));
    cmp({tag, " R3 R4"}, "pad_out", 32'(pad_out), 32'(exp_out()));
    cmp({tag, " R4"}, "alt_in", 32'(alt_in), 32'(aexp));
    cmp({tag, " R9"}, "irq", 32'(irq), 32'(|(m_stat & ~m_nmie)));
    cmp({tag, " R9"}, "nmi", 32'(nmi), 32'(|(m_stat & m_nmie)));
    st  = exp_state();
    clr = (w && a[4:2] == 3'd4) ? d[13:0] : 14'd0;
    @(posedge clk);
    if (!rst_n) begin
      m_func = '0; m_dir = '0; m_data = '0; m_lvl = '0; m_stat = '0; m_nmie = '0;
    end else begin
      m_stat = (m_stat & ~clr) | ~(st ^ m_lvl);
      if (w) case (a[4:2])
        3'd0: m_func = d[13:0];
        3'd1: m_dir  = d[13:0];
        3'd2: m_data = d[13:0];
        3'd3: m_lvl  = d[13:0];
        3'd5: m_nmie = d[13:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    // peripheral-driven pins derived from the listed receive pins 1,3,9,11
    alt_drives = '1;
    foreach (alt_drives[n]) if (n == 1 || n == 3 || n == 9 || n == 11) alt_drives[n] = 1'b0;

    @(negedge clk);
    // R1: reset state on every word and output
    for (int i = 0; i < 8; i++) cyc(5'(i * 4), 1'b1, 32'hFFFF_FFFF, 14'h3FFF, 14'h3FFF, "R1");
    rst_n = 1'b1;

    // R2: upper bits and unmapped words
    cyc(5'h04, 1'b1, 32'hFFFF_FFFF, 14'h0000, 14'h0, "R2");
    cyc(5'h04, 1'b0, 32'h0, 14'h0000, 14'h0, "R2");
    cyc(5'h18, 1'b1, 32'h1234_5678, 14'h0, 14'h0, "R2");
    cyc(5'h1C, 1'b0, 32'h0, 14'h0, 14'h0, "R2");
    // R3/R5: mixed direction, data read shows driven and pad values
    cyc(5'h04, 1'b1, 32'h0000_00FF, 14'h0, 14'h0, "R3");
    cyc(5'h08, 1'b1, 32'h0000_3CA5, 14'h2A5A, 14'h0, "R3");
    cyc(5'h08, 1'b0, 32'h0, 14'h2A5A, 14'h0, "R5");
    cyc(5'h08, 1'b0, 32'h0, 14'h15A5, 14'h3FFF, "R5");
    // R6/R7: level all ones, then clear and move level away
    cyc(5'h10, 1'b1, 32'h3FFF, 14'h0, 14'h0, "R8");
    cyc(5'h0C, 1'b1, 32'h3FFF, 14'h3F00, 14'h0, "R6");
    cyc(5'h10, 1'b0, 32'h0, 14'h3F00, 14'h0, "R6");
    cyc(5'h0C, 1'b1, 32'h0000, 14'h3FFF, 14'h0, "R7");
    cyc(5'h10, 1'b0, 32'h0, 14'h3FFF, 14'h0, "R7");
    // R8: clear while match persists (set wins), then once match is gone
    cyc(5'h10, 1'b1, 32'h3FFF, 14'h3FFF, 14'h0, "R8");
    cyc(5'h10, 1'b0, 32'h0, 14'h3FFF, 14'h0, "R8");
    cyc(5'h0C, 1'b1, 32'h00A5, 14'h3FFF, 14'h0, "R8");
    cyc(5'h10, 1'b1, 32'h3FFF, 14'h3F00, 14'h0, "R8");
    cyc(5'h10, 1'b0, 32'h0, 14'h3F00, 14'h0, "R8");
    // R9: split pending bits between the two outputs
    cyc(5'h14, 1'b1, 32'h0F0F, 14'h3F00, 14'h0, "R9");
    cyc(5'h10, 1'b1, 32'h30F0, 14'h3F00, 14'h0, "R9");
    cyc(5'h14, 1'b1, 32'h3FFF, 14'h3F00, 14'h0, "R9");
    cyc(5'h14, 1'b1, 32'h0000, 14'h3F00, 14'h0, "R9");
    // R4: peripheral mode on all pins with several patterns
    cyc(5'h00, 1'b1, 32'h3FFF, 14'h0ABC, 14'h1234, "R4");
    cyc(5'h08, 1'b0, 32'h0, 14'h0ABC, 14'h1234, "R4");
    cyc(5'h08, 1'b0, 32'h0, 14'h3543, 14'h2DCB, "R4");
    cyc(5'h00, 1'b1, 32'h0A0A, 14'h3FFF, 14'h3FFF, "R4");
    cyc(5'h08, 1'b0, 32'h0, 14'h3FFF, 14'h0000, "R4");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom;
      r2 = $urandom;
      cyc(5'({r1[2:0], 2'b00}), (r1[5:3] < 3'd3), r2, r1[29:16], r2[29:16], "mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule